// File: doc/BRIEF.md
# Real-Time Task Dispatch Controller

This block is the runtime core of a hardware task scheduler for a real-time processor. It holds a small table of periodic tasks, each with a period and a static priority. A free-running tick timer advances a time base. Every task waits in a sleep set keyed by its next activation time. When that time arrives, the task is released into a ready set with an absolute deadline of activation plus period, and its next activation moves one period further on.

The ready set is ordered either by earliest absolute deadline or by static priority, chosen by a mode input. A current-task register holds the running task. When the ready head strictly outranks the running task, or when nothing is running, the controller swaps the head in and raises an interrupt to the CPU. A preempted task goes back into the ready set with the deadline it already had. The ID of the task to run next is visible on a register output. The CPU reports job completion with a pulse and acknowledges the interrupt with another pulse.

The task table is loaded through a write port while the scheduler is disabled. Loading a task places it in the sleep set with activation time zero.

Top module: `sched_ctrl`

## Requirements
- R1: After reset, `irq`, `missed`, `cur_valid`, `next_id` and `now_time` are all zero.
- R2: A table write (`init_we`) loads the period and priority of task `init_id` and gives it activation time zero, but only while `en` is low. While `en` is high the write is ignored and the task never runs.
- R3: While `en` is high, `now_time` increases by exactly one every `TICK_DIV` clock cycles, starting from the first enabled edge. While `en` is low it holds its value.
- R4: While enabled, a loaded task whose activation time is at or below `now_time` is released. At most one task is released per cycle, and the lowest ID goes first. On release, the deadline becomes activation plus period and the next activation becomes activation plus period.
- R5: With `order_mode` = 0, a smaller absolute deadline outranks a larger one.
- R6: With `order_mode` = 1, a smaller priority value outranks a larger one.
- R7: When no task is running and the ready set is not empty, the ready head becomes the current task. `next_id` shows its ID, and `irq` is raised.
- R8: A ready head that strictly outranks the running task preempts it. The preempted task returns to the ready set with its deadline unchanged.
- R9: A `done_cmd` pulse while a task is running clears `cur_valid` on the next edge. Dispatch then follows by R7, and if the ready set is empty, no interrupt is raised.
- R10: `irq` stays high until an `irq_ack` pulse, which clears both `irq` and `missed`.
- R11: A switch that occurs while `irq` is high and is not being acknowledged sets `missed`. `next_id` always shows the ID of the latest switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Scheduler enable; gates timer, release and dispatch |
| order_mode | input | 1 | 0: earliest deadline first, 1: static priority |
| init_we | input | 1 | Table write strobe, honoured only while disabled |
| init_id | input | IW | Task ID to load |
| init_period | input | TW | Task period in ticks |
| init_prio | input | PW | Task priority, smaller is more urgent |
| done_cmd | input | 1 | Current job complete, one-cycle pulse |
| irq_ack | input | 1 | Interrupt acknowledge, one-cycle pulse |
| irq | output | 1 | Task-switch interrupt |
| missed | output | 1 | A switch occurred while the interrupt was pending |
| next_id | output | IW | ID of the task most recently switched in |
| cur_valid | output | 1 | A task is currently running |
| now_time | output | TW | Tick time base |

## Verification
The properties assume that `done_cmd` and `irq_ack` are single-cycle pulses. They also assume that `order_mode` is held constant while enabled, and that no task period is zero. Under these assumptions, a falling interrupt can only follow an acknowledge, and any change of `next_id` implies a pending interrupt. The directed stimulus loads nonzero periods and changes the ordering mode only across a reset. It drives completion only when a task is running, with one exception: the ignored-write case, where the table write is issued on purpose while enabled.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic {
        ORDER_DEADLINE = 1'b0,
        ORDER_PRIORITY = 1'b1
    } order_e;
endpackage

// File: rtl/sched_tick.sv
module sched_tick #(
    parameter int TICK_DIV = 4,
    parameter int TW       = 16,
    localparam int CW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [TW-1:0] now
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] now;
    } tick_t;

    tick_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (en) begin
            if (t_q.cnt == CW'(TICK_DIV - 1)) begin
                t_d.cnt = '0;
                t_d.now = t_q.now + 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign now = t_q.now;
endmodule

// File: rtl/sched_rel_pick.sv
module sched_rel_pick #(
    parameter int N  = 4,
    parameter int TW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][TW-1:0] act,
    input  logic [TW-1:0]        now,
    output logic                 hit,
    output logic [IW-1:0]        id
);
    logic [N-1:0] due;

    for (genvar g = 0; g < N; g++) begin : g_due
        assign due[g] = valid[g] && (act[g] <= now);
    end

    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (due[i]) begin
                hit = 1'b1;
                id  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sched_rdy_pick.sv
module sched_rdy_pick #(
    parameter int N  = 4,
    parameter int KW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         rdy,
    input  logic [N-1:0][KW-1:0] key,
    output logic                 any,
    output logic [IW-1:0]        id,
    output logic [KW-1:0]        best
);
    always_comb begin
        any  = 1'b0;
        id   = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (rdy[i] && (!any || key[i] < best)) begin
                any  = 1'b1;
                id   = IW'(i);
                best = key[i];
            end
        end
    end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
    import sched_pkg::*;
#(
    parameter int N        = 4,
    parameter int TW       = 16,
    parameter int PW       = 4,
    parameter int TICK_DIV = 4,
    localparam int IW      = (N > 1) ? $clog2(N) : 1,
    localparam int KW      = (TW > PW) ? TW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          order_mode,
    input  logic          init_we,
    input  logic [IW-1:0] init_id,
    input  logic [TW-1:0] init_period,
    input  logic [PW-1:0] init_prio,
    input  logic          done_cmd,
    input  logic          irq_ack,
    output logic          irq,
    output logic          missed,
    output logic [IW-1:0] next_id,
    output logic          cur_valid,
    output logic [TW-1:0] now_time
);
    typedef struct packed {
        logic [N-1:0]         valid;
        logic [N-1:0]         rdy;
        logic [N-1:0][TW-1:0] period;
        logic [N-1:0][TW-1:0] act;
        logic [N-1:0][TW-1:0] dl;
        logic [N-1:0][PW-1:0] prio;
        logic                 cur_v;
        logic [IW-1:0]        cur_id;
        logic [TW-1:0]        cur_dl;
        logic                 irq;
        logic                 missed;
        logic [IW-1:0]        nid;
    } st_t;

    st_t s_d, s_q;

    logic [TW-1:0]        now;
    logic                 rel_hit;
    logic [IW-1:0]        rel_id;
    logic [N-1:0][KW-1:0] keys;
    logic                 head_any;
    logic [IW-1:0]        head_id;
    logic [KW-1:0]        head_key;
    logic [KW-1:0]        cur_key;
    logic                 sw;
    order_e               ord;

    assign ord = order_e'(order_mode);

    sched_tick #(.TICK_DIV(TICK_DIV), .TW(TW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .now(now)
    );

    sched_rel_pick #(.N(N), .TW(TW)) u_rel (
        .valid(s_q.valid), .act(s_q.act), .now(now),
        .hit(rel_hit), .id(rel_id)
    );

    for (genvar g = 0; g < N; g++) begin : g_key
        assign keys[g] = (ord == ORDER_PRIORITY) ? KW'(s_q.prio[g]) : KW'(s_q.dl[g]);
    end

    sched_rdy_pick #(.N(N), .KW(KW)) u_rdy (
        .rdy(s_q.rdy), .key(keys),
        .any(head_any), .id(head_id), .best(head_key)
    );

    assign cur_key = (ord == ORDER_PRIORITY) ? KW'(s_q.prio[s_q.cur_id]) : KW'(s_q.cur_dl);

    always_comb begin
        s_d = s_q;
        sw  = 1'b0;

        // table load, disabled only
        if (!en && init_we) begin
            s_d.valid[init_id]  = 1'b1;
            s_d.period[init_id] = init_period;
            s_d.prio[init_id]   = init_prio;
            s_d.act[init_id]    = '0;
            s_d.dl[init_id]     = '0;
            s_d.rdy[init_id]    = 1'b0;
        end

        // release of one due task; a still-pending job is dropped
        if (en && rel_hit) begin
            s_d.act[rel_id] = s_q.act[rel_id] + s_q.period[rel_id];
            if (!s_q.rdy[rel_id] && !(s_q.cur_v && s_q.cur_id == rel_id)) begin
                s_d.rdy[rel_id] = 1'b1;
                s_d.dl[rel_id]  = s_q.act[rel_id] + s_q.period[rel_id];
            end
        end

        // completion, dispatch, preemption
        if (en && done_cmd && s_q.cur_v) begin
            s_d.cur_v = 1'b0;
        end else if (en && head_any && (!s_q.cur_v || head_key < cur_key)) begin
            sw = 1'b1;
            s_d.rdy[head_id] = 1'b0;
            if (s_q.cur_v) begin
                s_d.rdy[s_q.cur_id] = 1'b1;
                s_d.dl[s_q.cur_id]  = s_q.cur_dl;
            end
            s_d.cur_v  = 1'b1;
            s_d.cur_id = head_id;
            s_d.cur_dl = s_q.dl[head_id];
            s_d.nid    = head_id;
        end

        // interrupt and missed-switch flag
        if (irq_ack) begin
            s_d.irq    = 1'b0;
            s_d.missed = 1'b0;
        end
        if (sw) begin
            if (s_q.irq && !irq_ack) s_d.missed = 1'b1;
            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq       = s_q.irq;
    assign missed    = s_q.missed;
    assign next_id   = s_q.nid;
    assign cur_valid = s_q.cur_v;
    assign now_time  = now;
endmodule

// File: rtl/sched_ctrl_chk.sv
module sched_ctrl_chk #(
    parameter int TW = 16,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          done_cmd,
    input logic          irq_ack,
    input logic          irq,
    input logic          missed,
    input logic [IW-1:0] next_id,
    input logic          cur_valid,
    input logic [TW-1:0] now_time
);
    // R10
    irq_fall_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));

    // R11
    missed_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        missed |-> irq);

    // R11
    missed_rise_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(missed) |-> $past(irq));

    // R3
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(now_time));

    // R3
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_time != $past(now_time)) |-> (now_time == TW'($past(now_time) + 1'b1)));

    // R7
    dispatch_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_valid) |-> irq);

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(done_cmd) && $past(cur_valid)) |-> !cur_valid);

    // R11
    id_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_id != $past(next_id)) |-> irq);
endmodule

bind sched_ctrl sched_ctrl_chk #(.TW(TW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .done_cmd(done_cmd), .irq_ack(irq_ack),
    .irq(irq), .missed(missed), .next_id(next_id), .cur_valid(cur_valid),
    .now_time(now_time)
);

// File: tb/tb_sched_ctrl.sv
module tb_sched_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int TW = 16;
    localparam int PW = 4;
    localparam int IW = 2;
    localparam int TICK = 8;

    logic          clk = 1'b0;
    logic          rst_n, en, order_mode, init_we, done_cmd, irq_ack;
    logic [IW-1:0] init_id;
    logic [TW-1:0] init_period;
    logic [PW-1:0] init_prio;
    logic          irq, missed, cur_valid;
    logic [IW-1:0] next_id;
    logic [TW-1:0] now_time;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sched_ctrl #(.N(N), .TW(TW), .PW(PW), .TICK_DIV(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .order_mode(order_mode),
        .init_we(init_we), .init_id(init_id), .init_period(init_period),
        .init_prio(init_prio), .done_cmd(done_cmd), .irq_ack(irq_ack),
        .irq(irq), .missed(missed), .next_id(next_id),
        .cur_valid(cur_valid), .now_time(now_time)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; en = 1'b0; order_mode = mode; init_we = 1'b0;
        init_id = '0; init_period = '0; init_prio = '0;
        done_cmd = 1'b0; irq_ack = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic load(input int id, input int per, input int pr);
        init_we = 1'b1; init_id = IW'(id);
        init_period = TW'(per); init_prio = PW'(pr);
        step(1);
        init_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0; step(1);
    endtask

    task automatic done();
        done_cmd = 1'b1; step(1); done_cmd = 1'b0; step(2);
    endtask

    task automatic wait_time(input int t);
        while (now_time != TW'(t)) step(1);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(irq, 0, "R1 irq");
        chk(missed, 0, "R1 missed");
        chk(cur_valid, 0, "R1 cur_valid");
        chk(next_id, 0, "R1 next_id");
        chk(now_time, 0, "R1 now_time");
    endtask

    task automatic t_timer();
        do_reset(1'b0);
        en = 1'b1;
        step(40);
        chk(now_time, 40 / TICK, "R3 time after 40 enabled cycles");
        en = 1'b0;
        step(20);
        chk(now_time, 40 / TICK, "R3 time holds while disabled");
    endtask

    task automatic t_edf();
        do_reset(1'b0);
        load(0, 20, 2);
        load(1, 8, 1);
        load(2, 50, 0);
        en = 1'b1;
        step(6);
        chk(cur_valid, 1, "R7 dispatch on idle");
        chk(next_id, 1, "R5 earliest deadline runs");
        chk(irq, 1, "R7 irq raised");
        chk(missed, 1, "R11 second switch before ack");
        step(3);
        chk(irq, 1, "R10 irq held without ack");
        ack();
        chk(irq, 0, "R10 irq cleared by ack");
        chk(missed, 0, "R10 missed cleared by ack");
        done();
        chk(next_id, 0, "R9 next head after completion");
        chk(irq, 1, "R9 irq on reload");
        chk(missed, 0, "R11 no missed after ack");
        ack();
        wait_time(8);
        step(4);
        chk(next_id, 1, "R4 re-release deadline 16 preempts 20");
        chk(irq, 1, "R8 irq on preemption");
        ack();
        done();
        chk(next_id, 0, "R8 preempted task resumes with old deadline");
        chk(cur_valid, 1, "R8 resumed task running");
    endtask

    task automatic t_prio();
        do_reset(1'b1);
        load(0, 20, 2);
        load(1, 8, 1);
        load(2, 50, 0);
        en = 1'b1;
        step(6);
        chk(next_id, 2, "R6 smallest priority value runs");
        ack();
        done();
        chk(next_id, 1, "R6 next by priority");
        ack();
        done();
        chk(next_id, 0, "R6 last by priority");
        ack();
        done();
        step(3);
        chk(cur_valid, 0, "R9 idle after last completion");
        chk(irq, 0, "R9 no irq when ready set empty");
    endtask

    task automatic t_ignore();
        do_reset(1'b1);
        load(0, 200, 5);
        en = 1'b1;
        step(4);
        chk(next_id, 0, "R2 loaded task dispatched");
        ack();
        load(3, 2, 0);
        step(60);
        chk(irq, 0, "R2 enabled write causes no switch");
        chk(next_id, 0, "R2 enabled write ignored");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timer();
        t_edf();
        t_prio();
        t_ignore();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule